// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache-line misses that are still waiting on memory, so that an in-order pipeline can let load instructions retire from the memory stage without waiting for their data. Each entry covers one whole memory line. For every word of that line, the entry records which destination register, if any, is waiting for it. A load miss either opens a new entry, which sends one memory request, or joins an entry that already covers its line. In both cases the load's destination register is marked empty in a per-register scoreboard.

Decode asks the scoreboard about its source registers and holds an instruction only while a source is still empty. When memory returns a line, the entry writes each waiting word to its register, one per cycle, and marks each of those registers full. The entry is released after its last word has been written. The cache arrays and the memory are outside this block.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is in use, every register reads as full, and `miss_stall`, `memreq_valid` and `wb_valid` are low.
- R2: An accepted miss (`miss_valid` high, `miss_stall` low) to a line that no entry covers claims the lowest-numbered free entry. On the following cycle `memreq_valid` is high for exactly one cycle, with `memreq_line` equal to the miss line.
- R3: An accepted miss to a line that an entry already covers, where the fill has not yet arrived and the requested word is unclaimed, joins that entry. No memory request is issued.
- R4: A miss to an uncovered line is stalled while all NUM_ENT entries are in use.
- R5: A miss whose word is already claimed in the covering entry is stalled.
- R6: A miss whose destination register is already empty is stalled.
- R7: A miss to a line whose fill has already arrived is stalled until that entry is released.
- R8: A fill arrives with `fill_valid` high. Word w of the line sits at bits `[w*WORD_W +: WORD_W]` of `fill_data`. The cycle after the fill is taken, `wb_valid` is high with the lowest waiting word's register and data. Each further cycle delivers the next waiting word in ascending word order. Filled entries are served lowest-numbered first.
- R9: A register reads as full in the same cycle in which its writeback appears on `wb_valid`/`wb_rd`.
- R10: After its last writeback an entry is free. A new miss to the same line then allocates again and issues a new memory request.
- R11: A fill whose line matches no pending, unfilled entry has no effect: no writeback follows, and entry occupancy is unchanged.
- R12: `qry_empty` shows, in the same cycle, whether register `qry_reg` is waiting on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Load miss presented |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | log2(WORDS) | Word within the line |
| miss_rd | input | log2(NREG) | Destination register of the load |
| miss_stall | output | 1 | Miss cannot be taken this cycle |
| memreq_valid | output | 1 | Memory line request (one cycle) |
| memreq_line | output | LINE_AW | Line address being requested |
| fill_valid | input | 1 | Line data returned from memory |
| fill_line | input | LINE_AW | Line address of the returned data |
| fill_data | input | WORDS*WORD_W | Words of the line, word 0 in the low bits |
| wb_valid | output | 1 | Register writeback this cycle |
| wb_rd | output | log2(NREG) | Register being written |
| wb_data | output | WORD_W | Data written to the register |
| qry_reg | input | log2(NREG) | Register queried by decode |
| qry_empty | output | 1 | Queried register still waits on a miss |

## Verification
The assertions take for granted that a miss is only counted as taken in a cycle where `miss_stall` is low. They also take for granted that `fill_valid` carries at most one line per cycle, and that no fill is repeated for an entry whose line has already arrived. The bench keeps within these assumptions by drawing miss and fill lines from a small pool. A fill for a line with no entry is harmless by design, and these fills are mixed in on purpose. Every cycle a behavioural model of entries, waiters and the scoreboard predicts the stall, request, writeback and query outputs. Directed steps first force each stall reason, the ordering of writebacks and the reuse of an entry.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Index of the least significant set bit; 0 when the vector is empty.
  function automatic int unsigned lowest_one(input logic [63:0] v);
    lowest_one = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) lowest_one = i;
    end
  endfunction
endpackage

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
  parameter int NREG = 32,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [REG_AW-1:0] set_reg,
  input  logic              clr_en,
  input  logic [REG_AW-1:0] clr_reg,
  input  logic [REG_AW-1:0] q_reg,
  output logic [NREG-1:0]   empty_vec,
  output logic              q_empty
);
  logic [NREG-1:0] empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= '0;
    end else begin
      if (clr_en) empty_q[clr_reg] <= 1'b0;
      if (set_en) empty_q[set_reg] <= 1'b1;
    end
  end

  assign empty_vec = empty_q;
  assign q_empty   = empty_q[q_reg];

  // R6: a register is only marked empty while it is full
  a_r6_set_when_full: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !empty_q[set_reg]);
  // R9: a writeback only releases a register that was waiting
  a_r9_clear_when_empty: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> empty_q[clr_reg]);
  // R9: the released register reads full one cycle later
  a_r9_full_after_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_reg == clr_reg)) |=> !empty_q[$past(clr_reg)]);
endmodule

// File: rtl/mshr_slot.sv
module mshr_slot #(
  parameter int LINE_AW = 26,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  parameter int REG_AW  = 5,
  localparam int OFS_W  = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_en,
  input  logic                     merge_en,
  input  logic [LINE_AW-1:0]       req_line,
  input  logic [OFS_W-1:0]         req_word,
  input  logic [REG_AW-1:0]        req_rd,
  input  logic                     fill_valid,
  input  logic [LINE_AW-1:0]       fill_line,
  input  logic [WORDS*WORD_W-1:0]  fill_data,
  input  logic                     drain_en,
  input  logic [OFS_W-1:0]         drain_word,
  output logic                     busy,
  output logic                     filled,
  output logic                     hit,
  output logic                     claimed,
  output logic [WORDS-1:0]         want,
  output logic [WORDS*REG_AW-1:0]  rd_flat,
  output logic [WORDS*WORD_W-1:0]  data_flat
);
  logic               busy_q, filled_q;
  logic [LINE_AW-1:0] line_q;
  logic [WORDS-1:0]   want_q;
  logic [WORDS-1:0]   want_left;
  logic [REG_AW-1:0]  rd_mem [WORDS];
  logic [WORD_W-1:0]  dat_mem [WORDS];
  logic               fill_hit;

  assign fill_hit  = fill_valid && busy_q && !filled_q && (line_q == fill_line);
  assign want_left = want_q & ~(WORDS'(1) << drain_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      filled_q <= 1'b0;
      want_q   <= '0;
    end else if (alloc_en) begin
      busy_q   <= 1'b1;
      filled_q <= 1'b0;
      want_q   <= WORDS'(1) << req_word;
    end else begin
      if (merge_en) want_q[req_word] <= 1'b1;
      if (fill_hit) filled_q <= 1'b1;
      if (drain_en) begin
        want_q[drain_word] <= 1'b0;
        if (want_left == '0) begin
          busy_q   <= 1'b0;
          filled_q <= 1'b0;
        end
      end
    end
  end

  // storage without reset; validity is carried by busy_q and want_q
  always_ff @(posedge clk) begin
    if (alloc_en) line_q <= req_line;
    if (alloc_en || merge_en) rd_mem[req_word] <= req_rd;
    if (fill_hit) begin
      for (int w = 0; w < WORDS; w++) dat_mem[w] <= fill_data[w*WORD_W +: WORD_W];
    end
  end

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_out
      assign rd_flat[g*REG_AW +: REG_AW]   = rd_mem[g];
      assign data_flat[g*WORD_W +: WORD_W] = dat_mem[g];
    end
  endgenerate

  assign busy    = busy_q;
  assign filled  = filled_q;
  assign hit     = busy_q && (line_q == req_line);
  assign claimed = want_q[req_word];
  assign want    = want_q;

  // R2: allocation only lands in a free entry
  a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> !busy_q);
  // R3: a merge joins an open, unfilled entry on an unclaimed word
  a_r3_merge_open_word: assert property (@(posedge clk) disable iff (rst)
    merge_en |-> (busy_q && !filled_q && !want_q[req_word]));
  // R8: writeback only drains a filled entry's waiting word
  a_r8_drain_ready: assert property (@(posedge clk) disable iff (rst)
    drain_en |-> (filled_q && want_q[drain_word]));
endmodule

// File: rtl/mshr_drain_pick.sv
module mshr_drain_pick #(
  parameter int NUM_ENT = 4,
  parameter int WORDS   = 4,
  localparam int ENT_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int OFS_W  = $clog2(WORDS)
) (
  input  logic [NUM_ENT-1:0]       ready,
  input  logic [NUM_ENT*WORDS-1:0] want_all,
  output logic                     pick_valid,
  output logic [ENT_W-1:0]         pick_ent,
  output logic [OFS_W-1:0]         pick_word
);
  logic [WORDS-1:0] sel_want;

  always_comb begin
    pick_valid = |ready;
    pick_ent   = ENT_W'(mshr_pkg::lowest_one(64'(ready)));
    sel_want   = want_all[pick_ent*WORDS +: WORDS];
    pick_word  = OFS_W'(mshr_pkg::lowest_one(64'(sel_want)));
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int NUM_ENT = 4,
  parameter int LINE_AW = 26,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  parameter int NREG    = 32,
  localparam int OFS_W  = $clog2(WORDS),
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_valid,
  input  logic [LINE_AW-1:0]      miss_line,
  input  logic [OFS_W-1:0]        miss_word,
  input  logic [REG_AW-1:0]       miss_rd,
  output logic                    miss_stall,
  output logic                    memreq_valid,
  output logic [LINE_AW-1:0]      memreq_line,
  input  logic                    fill_valid,
  input  logic [LINE_AW-1:0]      fill_line,
  input  logic [WORDS*WORD_W-1:0] fill_data,
  output logic                    wb_valid,
  output logic [REG_AW-1:0]       wb_rd,
  output logic [WORD_W-1:0]       wb_data,
  input  logic [REG_AW-1:0]       qry_reg,
  output logic                    qry_empty
);
  localparam int ENT_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [NUM_ENT-1:0]              s_busy, s_filled, s_hit, s_claimed;
  logic [NUM_ENT-1:0]              alloc_vec, merge_vec, drain_vec;
  logic [NUM_ENT*WORDS-1:0]        s_want;
  logic [NUM_ENT*WORDS*REG_AW-1:0] s_rd;
  logic [NUM_ENT*WORDS*WORD_W-1:0] s_data;
  logic [NREG-1:0]                 sb_empty;

  logic             match_any, free_any, stall_c, accept;
  logic [ENT_W-1:0] free_idx;
  logic             pick_valid;
  logic [ENT_W-1:0] pick_ent;
  logic [OFS_W-1:0] pick_word;
  logic [REG_AW-1:0] pick_rd;
  logic [WORD_W-1:0] pick_data;

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_slot
      mshr_slot #(
        .LINE_AW(LINE_AW), .WORDS(WORDS), .WORD_W(WORD_W), .REG_AW(REG_AW)
      ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_vec[g]),
        .merge_en  (merge_vec[g]),
        .req_line  (miss_line),
        .req_word  (miss_word),
        .req_rd    (miss_rd),
        .fill_valid(fill_valid),
        .fill_line (fill_line),
        .fill_data (fill_data),
        .drain_en  (drain_vec[g]),
        .drain_word(pick_word),
        .busy      (s_busy[g]),
        .filled    (s_filled[g]),
        .hit       (s_hit[g]),
        .claimed   (s_claimed[g]),
        .want      (s_want[g*WORDS +: WORDS]),
        .rd_flat   (s_rd[g*WORDS*REG_AW +: WORDS*REG_AW]),
        .data_flat (s_data[g*WORDS*WORD_W +: WORDS*WORD_W])
      );
    end
  endgenerate

  // request side: merge, allocate or stall
  always_comb begin
    match_any  = |s_hit;
    free_any   = ~&s_busy;
    free_idx   = ENT_W'(mshr_pkg::lowest_one(64'(~s_busy)));
    stall_c    = sb_empty[miss_rd] || (|(s_hit & s_filled)) || (|(s_hit & s_claimed))
                 || (!match_any && !free_any);
    miss_stall = miss_valid && stall_c;
    accept     = miss_valid && !stall_c;
    merge_vec  = accept ? s_hit : '0;
    alloc_vec  = (accept && !match_any) ? (NUM_ENT'(1) << free_idx) : '0;
  end

  mshr_drain_pick #(.NUM_ENT(NUM_ENT), .WORDS(WORDS)) u_pick (
    .ready     (s_busy & s_filled),
    .want_all  (s_want),
    .pick_valid(pick_valid),
    .pick_ent  (pick_ent),
    .pick_word (pick_word)
  );

  always_comb begin
    drain_vec = pick_valid ? (NUM_ENT'(1) << pick_ent) : '0;
    pick_rd   = s_rd[(pick_ent*WORDS + pick_word)*REG_AW +: REG_AW];
    pick_data = s_data[(pick_ent*WORDS + pick_word)*WORD_W +: WORD_W];
  end

  mshr_scoreboard #(.NREG(NREG)) u_sb (
    .clk      (clk),
    .rst      (rst),
    .set_en   (accept),
    .set_reg  (miss_rd),
    .clr_en   (pick_valid),
    .clr_reg  (pick_rd),
    .q_reg    (qry_reg),
    .empty_vec(sb_empty),
    .q_empty  (qry_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      memreq_valid <= 1'b0;
      wb_valid     <= 1'b0;
    end else begin
      memreq_valid <= accept && !match_any;
      wb_valid     <= pick_valid;
    end
    if (accept && !match_any) memreq_line <= miss_line;
    if (pick_valid) begin
      wb_rd   <= pick_rd;
      wb_data <= pick_data;
    end
  end

  // R3: one line is never covered by two entries
  a_r3_single_cover: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_hit));
  // R2: a memory request follows a miss taken in the previous cycle
  a_r2_req_follows_miss: assert property (@(posedge clk) disable iff (rst)
    memreq_valid |-> $past(miss_valid && !miss_stall));
  // R9: the written register already reads full
  a_r9_wb_reg_full: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !sb_empty[wb_rd]);
  // R8: the picker only selects a word that is waiting
  a_r8_pick_has_waiter: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> s_want[pick_ent*WORDS + pick_word]);
endmodule

// File: tb/mshr_file_test.sv
`timescale 1ns/100ps
module mshr_file_test;
  localparam int NUM_ENT = 4;
  localparam int LINE_AW = 26;
  localparam int WORDS   = 4;
  localparam int WORD_W  = 32;
  localparam int NREG    = 32;
  localparam int OFS_W   = 2;
  localparam int REG_AW  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic                    miss_valid = 1'b0;
  logic [LINE_AW-1:0]      miss_line = '0;
  logic [OFS_W-1:0]        miss_word = '0;
  logic [REG_AW-1:0]       miss_rd = '0;
  logic                    miss_stall;
  logic                    memreq_valid;
  logic [LINE_AW-1:0]      memreq_line;
  logic                    fill_valid = 1'b0;
  logic [LINE_AW-1:0]      fill_line = '0;
  logic [WORDS*WORD_W-1:0] fill_data = '0;
  logic                    wb_valid;
  logic [REG_AW-1:0]       wb_rd;
  logic [WORD_W-1:0]       wb_data;
  logic [REG_AW-1:0]       qry_reg = '0;
  logic                    qry_empty;

  mshr_file #(
    .NUM_ENT(NUM_ENT), .LINE_AW(LINE_AW), .WORDS(WORDS), .WORD_W(WORD_W), .NREG(NREG)
  ) uut (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word), .miss_rd(miss_rd),
    .miss_stall(miss_stall),
    .memreq_valid(memreq_valid), .memreq_line(memreq_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .qry_reg(qry_reg), .qry_empty(qry_empty)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_AW-1:0] l, input int w);
    return 32'h5000_0000 + 32'(l) * 32'd16 + 32'(w);
  endfunction

  function automatic logic [WORDS*WORD_W-1:0] line_data(input logic [LINE_AW-1:0] l);
    logic [WORDS*WORD_W-1:0] d;
    for (int w = 0; w < WORDS; w++) d[w*WORD_W +: WORD_W] = word_of(l, w);
    return d;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit                 m_used [NUM_ENT];
  bit                 m_fill [NUM_ENT];
  logic [LINE_AW-1:0] m_line [NUM_ENT];
  int                 m_rd   [NUM_ENT][WORDS];
  logic [WORD_W-1:0]  m_dat  [NUM_ENT][WORDS];
  bit                 m_sb   [NREG];
  bit                 e_mreq = 0;
  logic [LINE_AW-1:0] e_mline = '0;
  bit                 e_wb = 0;
  int                 e_wrd = 0;
  logic [WORD_W-1:0]  e_wdat = '0;

  function automatic bit mdl_stall();
    if (m_sb[miss_rd]) return 1'b1;
    for (int i = 0; i < NUM_ENT; i++)
      if (m_used[i] && m_line[i] == miss_line)
        return m_fill[i] || (m_rd[i][miss_word] != -1);
    for (int i = 0; i < NUM_ENT; i++)
      if (!m_used[i]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin : model
    bit st;
    int dsl, dw, hit, fre, left;
    if (rst) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        m_used[i] = 0;
        m_fill[i] = 0;
      end
      for (int r = 0; r < NREG; r++) m_sb[r] = 0;
      e_mreq = 0;
      e_wb = 0;
    end else begin
      st = miss_valid && mdl_stall();
      dsl = -1; hit = -1; fre = -1;
      for (int i = 0; i < NUM_ENT; i++) begin
        if (dsl < 0 && m_used[i] && m_fill[i]) dsl = i;
        if (hit < 0 && m_used[i] && m_line[i] == miss_line) hit = i;
        if (fre < 0 && !m_used[i]) fre = i;
      end
      e_wb = 0;
      e_mreq = 0;
      if (dsl >= 0) begin
        dw = -1;
        for (int w = 0; w < WORDS; w++) if (dw < 0 && m_rd[dsl][w] != -1) dw = w;
        e_wb = 1;
        e_wrd = m_rd[dsl][dw];
        e_wdat = m_dat[dsl][dw];
        m_sb[e_wrd] = 0;
        m_rd[dsl][dw] = -1;
        left = 0;
        for (int w = 0; w < WORDS; w++) if (m_rd[dsl][w] != -1) left++;
        if (left == 0) begin
          m_used[dsl] = 0;
          m_fill[dsl] = 0;
        end
      end
      if (fill_valid) begin
        for (int i = 0; i < NUM_ENT; i++)
          if (i != dsl && m_used[i] && !m_fill[i] && m_line[i] == fill_line) begin
            m_fill[i] = 1;
            for (int w = 0; w < WORDS; w++) m_dat[i][w] = fill_data[w*WORD_W +: WORD_W];
          end
      end
      if (miss_valid && !st) begin
        m_sb[miss_rd] = 1;
        if (hit >= 0) begin
          m_rd[hit][miss_word] = miss_rd;
        end else begin
          m_used[fre] = 1;
          m_fill[fre] = 0;
          m_line[fre] = miss_line;
          for (int w = 0; w < WORDS; w++) m_rd[fre][w] = -1;
          m_rd[fre][miss_word] = miss_rd;
          e_mreq = 1;
          e_mline = miss_line;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 memreq_valid", memreq_valid, e_mreq);
      if (e_mreq) check("R2 memreq_line", memreq_line, e_mline);
      check("R8 wb_valid", wb_valid, e_wb);
      if (e_wb) begin
        check("R8 wb_rd", wb_rd, e_wrd);
        check("R8 wb_data", wb_data, e_wdat);
      end
      #1.5;
      check("R4 miss_stall model", miss_stall, miss_valid && mdl_stall());
      check("R12 qry_empty model", qry_empty, m_sb[qry_reg]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc();
    @(negedge clk);
    #0.5;
  endtask

  task automatic do_miss(input logic [LINE_AW-1:0] l, input int w, input int r);
    miss_valid = 1'b1;
    miss_line  = l;
    miss_word  = OFS_W'(w);
    miss_rd    = REG_AW'(r);
  endtask

  task automatic do_fill(input logic [LINE_AW-1:0] l);
    fill_valid = 1'b1;
    fill_line  = l;
    fill_data  = line_data(l);
  endtask

  localparam logic [LINE_AW-1:0] LA = 26'h10, LB = 26'h20, LC = 26'h30, LD = 26'h40, LE = 26'h50;

  initial begin
    repeat (4) @(negedge clk);
    #0.5;
    qry_reg = 5'd1;
    #0.2;
    check("R1 wb_valid", wb_valid, 0);
    check("R1 memreq_valid", memreq_valid, 0);
    check("R1 miss_stall", miss_stall, 0);
    check("R1 qry_empty", qry_empty, 0);
    rst = 1'b0;
    cyc();

    // R2: new line allocates and requests
    do_miss(LA, 0, 1);
    #0.2 check("R2 accept", miss_stall, 0);
    cyc();
    miss_valid = 1'b0;
    check("R2 request", memreq_valid, 1);
    check("R2 request line", memreq_line, LA);
    #0.2 check("R12 r1 empty", qry_empty, 1);

    // R3: merge into pending line, no request
    do_miss(LA, 2, 2);
    #0.2 check("R3 accept", miss_stall, 0);
    cyc();
    check("R3 no request", memreq_valid, 0);

    // R5: word already claimed
    do_miss(LA, 2, 3);
    #0.2 check("R5 claimed stall", miss_stall, 1);
    // R6: destination already empty
    do_miss(LB, 1, 1);
    #0.2 check("R6 busy reg stall", miss_stall, 1);

    do_miss(LB, 1, 4); cyc();
    do_miss(LC, 0, 5); cyc();
    do_miss(LD, 3, 6); cyc();
    // R4: all entries in use
    do_miss(LE, 0, 7);
    #0.2 check("R4 full stall", miss_stall, 1);
    miss_valid = 1'b0;

    // R11: fill for a line that no entry holds
    do_fill(LE); cyc();
    fill_valid = 1'b0; cyc();
    check("R11 no wb", wb_valid, 0);
    do_miss(LE, 0, 7);
    #0.2 check("R11 still full", miss_stall, 1);
    miss_valid = 1'b0;

    // R8/R7/R9: fill of line A drains word 0 then word 2
    do_fill(LA); cyc();
    fill_valid = 1'b0;
    do_miss(LA, 1, 8);
    #0.2 check("R7 draining stall", miss_stall, 1);
    miss_valid = 1'b0;
    cyc();
    check("R8 first wb", wb_valid, 1);
    check("R8 first rd", wb_rd, 1);
    check("R8 first data", wb_data, word_of(LA, 0));
    #0.2 check("R9 r1 full", qry_empty, 0);
    cyc();
    check("R8 second rd", wb_rd, 2);
    check("R8 second data", wb_data, word_of(LA, 2));
    cyc();
    check("R8 drain done", wb_valid, 0);

    // R10: freed entry reused
    do_miss(LE, 0, 7);
    #0.2 check("R10 accept", miss_stall, 0);
    cyc();
    miss_valid = 1'b0;
    check("R10 request", memreq_valid, 1);
    check("R10 request line", memreq_line, LE);

    // R8 ordering across entries
    do_miss(LC, 1, 9); cyc();
    miss_valid = 1'b0;
    do_fill(LD); cyc();
    do_fill(LC); cyc();
    fill_valid = 1'b0;
    check("R8 order D first", wb_rd, 6);
    cyc();
    check("R8 order C word0", wb_rd, 5);
    cyc();
    check("R8 order C word1", wb_rd, 9);
    do_fill(LB); cyc();
    do_fill(LE); cyc();
    fill_valid = 1'b0;
    repeat (4) cyc();

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      miss_valid = ($urandom_range(0, 1) == 1);
      miss_line  = LINE_AW'(16 * $urandom_range(1, 8));
      miss_word  = OFS_W'($urandom_range(0, WORDS-1));
      miss_rd    = REG_AW'($urandom_range(1, NREG-1));
      qry_reg    = REG_AW'($urandom_range(0, NREG-1));
      if ($urandom_range(0, 2) == 0) do_fill(LINE_AW'(16 * $urandom_range(1, 9)));
      else fill_valid = 1'b0;
      cyc();
    end
    miss_valid = 1'b0;
    fill_valid = 1'b0;
    repeat (5) cyc();
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule